// File: doc/BRIEF.md
# Five-Source Memory Access Priority Arbiter

This block sits in front of a single memory block and serves five kinds of access: data write, program write, data read, program read and instruction fetch. In every cycle it looks at the pending requests and grants exactly one of them, the highest-ranked. It then steers the chosen source's address, write data and direction onto the memory port. Sources that lose the comparison get no grant. They stall, holding their request, address and data, until they win. No fairness scheme is applied, so a low-ranked source can wait for as long as higher-ranked traffic continues.

The grant is resolved combinationally in the cycle the requests appear. The memory is synchronous, so read data comes back on the cycle after a read grant. A small return state machine remembers which reader was served and raises that reader's valid strobe alongside the shared read-data bus. Its states are RET_NONE, RET_DREAD, RET_PREAD and RET_FETCH. Every cycle it takes the transition named after the reader granted in that cycle: to RET_DREAD, RET_PREAD or RET_FETCH. When no reader is granted, it takes the transition to RET_NONE. Reset puts it in RET_NONE.

Two pairs of requests must never be raised together: the two write types, and program read with fetch. The arbiter raises an error flag in the same cycle when either pair appears. Priority resolution still proceeds normally during such a cycle. Program-side addresses are 22 bits wide and are zero-extended onto the 32-bit memory address.

Top module: `mem_prio_arb`

## Requirements
- R1: Ranking from highest to lowest is data write, program write, data read, program read, fetch. At most one grant is high in a cycle, and it belongs to the highest-ranked pending request. In the bench's request and grant vectors, bit 0 is data write, bit 1 is program write, bit 2 is data read, bit 3 is program read and bit 4 is fetch.
- R2: While a source is granted, `mem_addr` carries that source's address, zero-extended from 22 bits for the three program-side sources. `mem_wdata` carries the write data of a granted writer.
- R3: `mem_en` is high exactly when some grant is high. `mem_we` is high only when the granted source is data write or program write.
- R4: One cycle after a read grant, the `*_rvalid` of that reader alone is high and `rd_data` equals `mem_rdata`. In a cycle that follows no read grant, every `*_rvalid` is low.
- R5: `err_wr_clash` is high in exactly the cycles in which `dw_req` and `pw_req` are both high.
- R6: `err_rd_clash` is high in exactly the cycles in which `pr_req` and `if_req` are both high.
- R7: A source that is not granted receives no grant and no memory access. Once the higher-ranked requests drop, the held request is granted with its held address.
- R8: While `rst_n` is low, every grant, `mem_en` and every `*_rvalid` is low, whatever the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dw_req | input | 1 | Data write request |
| dw_addr | input | 32 | Data write address |
| dw_wdata | input | 32 | Data write value |
| dw_gnt | output | 1 | Data write grant |
| pw_req | input | 1 | Program write request |
| pw_addr | input | 22 | Program write address |
| pw_wdata | input | 32 | Program write value |
| pw_gnt | output | 1 | Program write grant |
| dr_req | input | 1 | Data read request |
| dr_addr | input | 32 | Data read address |
| dr_gnt | output | 1 | Data read grant |
| dr_rvalid | output | 1 | Data read result valid |
| pr_req | input | 1 | Program read request |
| pr_addr | input | 22 | Program read address |
| pr_gnt | output | 1 | Program read grant |
| pr_rvalid | output | 1 | Program read result valid |
| if_req | input | 1 | Instruction fetch request |
| if_addr | input | 22 | Fetch address |
| if_gnt | output | 1 | Fetch grant |
| if_rvalid | output | 1 | Fetch result valid |
| rd_data | output | 32 | Shared read-data return |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write select |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write value |
| mem_rdata | input | 32 | Memory read value, one cycle after a read access |
| err_wr_clash | output | 1 | Both write types requested together |
| err_rd_clash | output | 1 | Program read and fetch requested together |

## Verification
Two things can happen in the same cycle: the return of an earlier read, and a fresh grant to another source. The bench provokes this with a data read that stalls a fetch. One cycle later, `dr_rvalid` with the stored word must appear while `if_gnt` and the fetch address are on the memory port, and the fetch's own return must follow in the cycle after. A clash flag can also coincide with a grant. The vector table pairs illegal request sets with the grant they must still produce, and every such row is judged on both the flag and the grant.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int NSRC = 5;
    // Source index doubles as rank: lower index wins.
    typedef enum logic [2:0] {
        SRC_DW = 3'd0,
        SRC_PW = 3'd1,
        SRC_DR = 3'd2,
        SRC_PR = 3'd3,
        SRC_IF = 3'd4
    } src_e;

    typedef enum logic [1:0] {
        RET_NONE  = 2'd0,
        RET_DREAD = 2'd1,
        RET_PREAD = 2'd2,
        RET_FETCH = 2'd3
    } ret_state_e;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int N = 5
) (
    input  logic         enable,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [N:0] taken;

    assign taken[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_rank
        assign gnt[i]     = enable && req[i] && !taken[i];
        assign taken[i+1] = taken[i] || req[i];
    end
endmodule

// File: rtl/arb_clash_det.sv
module arb_clash_det (
    input  logic dw_req,
    input  logic pw_req,
    input  logic pr_req,
    input  logic if_req,
    output logic wr_clash,
    output logic rd_clash
);
    assign wr_clash = dw_req && pw_req;
    assign rd_clash = pr_req && if_req;
endmodule

// File: rtl/arb_rd_return.sv
module arb_rd_return
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gnt_dr,
    input  logic gnt_pr,
    input  logic gnt_if,
    output logic rv_dr,
    output logic rv_pr,
    output logic rv_if
);
    ret_state_e state, state_nx;

    always_comb begin
        if (gnt_dr)      state_nx = RET_DREAD;
        else if (gnt_pr) state_nx = RET_PREAD;
        else if (gnt_if) state_nx = RET_FETCH;
        else             state_nx = RET_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RET_NONE;
        else        state <= state_nx;
    end

    always_comb begin
        rv_dr = 1'b0;
        rv_pr = 1'b0;
        rv_if = 1'b0;
        unique case (state)
            RET_NONE:  ;
            RET_DREAD: rv_dr = 1'b1;
            RET_PREAD: rv_pr = 1'b1;
            RET_FETCH: rv_if = 1'b1;
        endcase
    end
endmodule

// File: rtl/mem_prio_arb.sv
module mem_prio_arb
    import arb_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DADDR_W = 32,
    parameter int PADDR_W = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dw_req,
    input  logic [DADDR_W-1:0] dw_addr,
    input  logic [DATA_W-1:0]  dw_wdata,
    output logic               dw_gnt,
    input  logic               pw_req,
    input  logic [PADDR_W-1:0] pw_addr,
    input  logic [DATA_W-1:0]  pw_wdata,
    output logic               pw_gnt,
    input  logic               dr_req,
    input  logic [DADDR_W-1:0] dr_addr,
    output logic               dr_gnt,
    output logic               dr_rvalid,
    input  logic               pr_req,
    input  logic [PADDR_W-1:0] pr_addr,
    output logic               pr_gnt,
    output logic               pr_rvalid,
    input  logic               if_req,
    input  logic [PADDR_W-1:0] if_addr,
    output logic               if_gnt,
    output logic               if_rvalid,
    output logic [DATA_W-1:0]  rd_data,
    output logic               mem_en,
    output logic               mem_we,
    output logic [DADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               err_wr_clash,
    output logic               err_rd_clash
);
    localparam int PAD_W = DADDR_W - PADDR_W;

    logic [NSRC-1:0]    req_v, gnt_v;
    logic [DADDR_W-1:0] addr_v  [NSRC];
    logic [DATA_W-1:0]  wdata_v [NSRC];
    logic [NSRC-1:0]    is_wr;

    assign req_v = {if_req, pr_req, dr_req, pw_req, dw_req};

    assign addr_v[SRC_DW] = dw_addr;
    assign addr_v[SRC_PW] = {{PAD_W{1'b0}}, pw_addr};
    assign addr_v[SRC_DR] = dr_addr;
    assign addr_v[SRC_PR] = {{PAD_W{1'b0}}, pr_addr};
    assign addr_v[SRC_IF] = {{PAD_W{1'b0}}, if_addr};

    assign wdata_v[SRC_DW] = dw_wdata;
    assign wdata_v[SRC_PW] = pw_wdata;
    assign wdata_v[SRC_DR] = '0;
    assign wdata_v[SRC_PR] = '0;
    assign wdata_v[SRC_IF] = '0;

    assign is_wr = 5'b00011;

    arb_prio_pick #(.N(NSRC)) u_pick (
        .enable (rst_n),
        .req    (req_v),
        .gnt    (gnt_v)
    );

    arb_clash_det u_clash (
        .dw_req   (dw_req),
        .pw_req   (pw_req),
        .pr_req   (pr_req),
        .if_req   (if_req),
        .wr_clash (err_wr_clash),
        .rd_clash (err_rd_clash)
    );

    arb_rd_return u_ret (
        .clk    (clk),
        .rst_n  (rst_n),
        .gnt_dr (gnt_v[SRC_DR]),
        .gnt_pr (gnt_v[SRC_PR]),
        .gnt_if (gnt_v[SRC_IF]),
        .rv_dr  (dr_rvalid),
        .rv_pr  (pr_rvalid),
        .rv_if  (if_rvalid)
    );

    // One-hot grant, so an AND-OR mux suffices.
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            mem_addr  |= addr_v[i]  & {DADDR_W{gnt_v[i]}};
            mem_wdata |= wdata_v[i] & {DATA_W{gnt_v[i]}};
            mem_we    |= is_wr[i] & gnt_v[i];
        end
    end

    assign mem_en  = |gnt_v;
    assign rd_data = mem_rdata;

    assign dw_gnt = gnt_v[SRC_DW];
    assign pw_gnt = gnt_v[SRC_PW];
    assign dr_gnt = gnt_v[SRC_DR];
    assign pr_gnt = gnt_v[SRC_PR];
    assign if_gnt = gnt_v[SRC_IF];
endmodule

// File: rtl/mem_prio_arb_chk.sv
module mem_prio_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic dw_req, pw_req, dr_req, pr_req, if_req,
    input logic dw_gnt, pw_gnt, dr_gnt, pr_gnt, if_gnt,
    input logic dr_rvalid, pr_rvalid, if_rvalid,
    input logic mem_en, mem_we,
    input logic err_wr_clash, err_rd_clash
);
    a_r1_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dw_gnt, pw_gnt, dr_gnt, pr_gnt, if_gnt}));
    a_r1_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
        dw_req |-> dw_gnt);
    a_r1_fetch_last: assert property (@(posedge clk) disable iff (!rst_n)
        if_gnt |-> !(dw_req || pw_req || dr_req || pr_req));
    a_r3_en_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (dw_gnt || pw_gnt || dr_gnt || pr_gnt || if_gnt));
    a_r3_we_writer: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (dw_gnt || pw_gnt));
    a_r4_dr_return: assert property (@(posedge clk) disable iff (!rst_n)
        dr_gnt |=> dr_rvalid);
    a_r4_if_return: assert property (@(posedge clk) disable iff (!rst_n)
        if_gnt |=> if_rvalid);
    a_r4_one_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dr_rvalid, pr_rvalid, if_rvalid}));
    a_r5_wr_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_req && pw_req) |-> err_wr_clash);
    a_r6_rd_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_req && if_req) |-> err_rd_clash);
    a_r7_loser_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_req && dr_req) |-> !pr_gnt);
    a_r8_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> !(mem_en || dw_gnt || if_gnt));
endmodule

bind mem_prio_arb mem_prio_arb_chk i_chk (
    .clk(clk), .rst_n(rst_n),
    .dw_req(dw_req), .pw_req(pw_req), .dr_req(dr_req), .pr_req(pr_req), .if_req(if_req),
    .dw_gnt(dw_gnt), .pw_gnt(pw_gnt), .dr_gnt(dr_gnt), .pr_gnt(pr_gnt), .if_gnt(if_gnt),
    .dr_rvalid(dr_rvalid), .pr_rvalid(pr_rvalid), .if_rvalid(if_rvalid),
    .mem_en(mem_en), .mem_we(mem_we),
    .err_wr_clash(err_wr_clash), .err_rd_clash(err_rd_clash)
);

// File: tb/test_mem_prio_arb.sv
module test_mem_prio_arb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dw_req = 0, pw_req = 0, dr_req = 0, pr_req = 0, if_req = 0;
    logic [31:0] dw_addr = '0, dr_addr = '0, dw_wdata = '0, pw_wdata = '0;
    logic [21:0] pw_addr = '0, pr_addr = '0, if_addr = '0;
    logic        dw_gnt, pw_gnt, dr_gnt, pr_gnt, if_gnt;
    logic        dr_rvalid, pr_rvalid, if_rvalid;
    logic [31:0] rd_data, mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_en, mem_we, err_wr_clash, err_rd_clash;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mem_prio_arb i_mem_prio_arb (.*);

    // Bench-side synchronous memory.
    logic [31:0] store [256];
    always @(posedge clk) begin
        if (mem_en && mem_we) store[mem_addr[7:0]] <= mem_wdata;
        if (mem_en && !mem_we) mem_rdata <= store[mem_addr[7:0]];
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic set_req(input logic [4:0] r);
        {if_req, pr_req, dr_req, pw_req, dw_req} = r;
    endtask

    function automatic logic [4:0] gnts();
        return {if_gnt, pr_gnt, dr_gnt, pw_gnt, dw_gnt};
    endfunction

    // Row layout: {req[4:0], gnt[4:0], wr_clash, rd_clash}
    localparam int NV = 13;
    localparam logic [11:0] VEC [NV] = '{
        {5'b00000, 5'b00000, 1'b0, 1'b0},
        {5'b00001, 5'b00001, 1'b0, 1'b0},
        {5'b00010, 5'b00010, 1'b0, 1'b0},
        {5'b00100, 5'b00100, 1'b0, 1'b0},
        {5'b01000, 5'b01000, 1'b0, 1'b0},
        {5'b10000, 5'b10000, 1'b0, 1'b0},
        {5'b11100, 5'b00100, 1'b0, 1'b1},
        {5'b00011, 5'b00001, 1'b1, 1'b0},
        {5'b11000, 5'b01000, 1'b0, 1'b1},
        {5'b10100, 5'b00100, 1'b0, 1'b0},
        {5'b01110, 5'b00010, 1'b0, 1'b0},
        {5'b11111, 5'b00001, 1'b1, 1'b1},
        {5'b10110, 5'b00010, 1'b0, 1'b0}
    };

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) store[i] = 32'h0;
        // R8: reset holds everything quiet even with all requests raised
        set_req(5'b11111);
        repeat (3) @(negedge clk);
        #1;
        chk("R8 grants", {27'd0, gnts()}, 32'd0);
        chk("R8 mem_en", {31'd0, mem_en}, 32'd0);
        chk("R8 rvalid", {29'd0, if_rvalid, pr_rvalid, dr_rvalid}, 32'd0);
        @(negedge clk);
        set_req(5'b00000);
        rst_n = 1'b1;

        dr_addr = 32'h40; pr_addr = 22'h41; if_addr = 22'h42;
        dw_addr = 32'h50; pw_addr = 22'h51;
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            set_req(VEC[v][11:7]);
            #1;
            chk("R1 grant", {27'd0, gnts()}, {27'd0, VEC[v][6:2]});
            chk("R5 wr clash", {31'd0, err_wr_clash}, {31'd0, VEC[v][1]});
            chk("R6 rd clash", {31'd0, err_rd_clash}, {31'd0, VEC[v][0]});
            chk("R3 mem_en", {31'd0, mem_en}, {31'd0, |VEC[v][6:2]});
            chk("R3 mem_we", {31'd0, mem_we}, {31'd0, |VEC[v][3:2]});
            @(negedge clk);
            set_req(5'b00000);
            #1;
            chk("R4 rvalid", {29'd0, if_rvalid, pr_rvalid, dr_rvalid}, {29'd0, VEC[v][6:4]});
        end

        // R2: data write drives port
        @(negedge clk);
        dw_addr = 32'h10; dw_wdata = 32'hA5A5_0001; set_req(5'b00001);
        #1;
        chk("R2 dw addr", mem_addr, 32'h10);
        chk("R2 dw wdata", mem_wdata, 32'hA5A5_0001);
        // R2: program write zero-extends its address
        @(negedge clk);
        pw_addr = 22'h3F0021; pw_wdata = 32'h1234_5678; set_req(5'b00010);
        #1;
        chk("R2 pw addr", mem_addr, 32'h003F_0021);
        chk("R2 pw wdata", mem_wdata, 32'h1234_5678);
        chk("R3 pw we", {31'd0, mem_we}, 32'd1);

        // R7: fetch stalls behind a data read, then is served with its held address
        @(negedge clk);
        dr_addr = 32'h10; if_addr = 22'h3F0021; set_req(5'b10100);
        #1;
        chk("R7 fetch stalled", {31'd0, if_gnt}, 32'd0);
        chk("R2 dr addr", mem_addr, 32'h10);
        chk("R3 dr no we", {31'd0, mem_we}, 32'd0);
        @(negedge clk);
        set_req(5'b10000);
        #1;
        chk("R4 dr rvalid", {29'd0, if_rvalid, pr_rvalid, dr_rvalid}, 32'd1);
        chk("R4 dr data", rd_data, 32'hA5A5_0001);
        chk("R7 fetch granted", {31'd0, if_gnt}, 32'd1);
        chk("R7 fetch addr", mem_addr, 32'h003F_0021);
        @(negedge clk);
        set_req(5'b00000);
        #1;
        chk("R4 if rvalid", {29'd0, if_rvalid, pr_rvalid, dr_rvalid}, 32'd4);
        chk("R4 if data", rd_data, 32'h1234_5678);
        @(negedge clk);
        #1;
        chk("R4 idle rvalid", {29'd0, if_rvalid, pr_rvalid, dr_rvalid}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule